// File: doc/BRIEF.md
# Skewed-Bank Search Window Memory

This block holds a square window of reference pixels and hands back, one cycle after a request, a macroblock-wide slice of any complete row or any complete column of that window. Pixels arrive a full row at a time. Each row is rotated across banks that are one pixel wide before it is stored, so the pixels of any image column end up in different banks. A column read therefore touches every bank exactly once, just as a row read does, and both kinds of read finish in a single access.

The window is split into four quadrant partitions. Two sit in the top half and two in the bottom half, and each is half the window wide and half the window high. Splitting the window this way keeps the rotate network on the write side and the unrotate network on the read side at half the window width. A read request names the direction (row or column), the line index and the starting offset. The block picks the two partitions that hold that line and puts their halves back into image order to form one full-length line. It then returns the 16 consecutive pixels that begin at the offset, with the offset saturated so the slice stays inside the line.

Top module: `skw_win_mem`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `rd_valid` and `rd_err` are 0.
- R2: A row read (`rd_col`=0) of line L at offset o returns pixels (L, o..o+15) of the last data written to row L. Pixel o+k appears on `rd_pix[k*8 +: 8]`. Within a written row, pixel c comes from `wr_pix[c*8 +: 8]`.
- R3: A column read (`rd_col`=1) of line L at offset o returns pixels (o..o+15, L), row o+k on `rd_pix[k*8 +: 8]`. This holds for lines in both column halves and for rows in both row halves.
- R4: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_req`=1, and 0 after a cycle without it.
- R5: An offset above 16 is treated as 16 and sets `rd_err` together with `rd_valid`. An offset of 16 or less leaves `rd_err` at 0.
- R6: A read and a write of the same row in the same cycle return the row's contents from before that write. The new data is visible to the next read.
- R7: In a cycle without `rd_req`, `rd_pix` keeps its previous value, even if a write happens in that cycle.
- R8: Writing row r changes no pixel of any other row. Column reads across the window show only row r updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the read-side state |
| wr_en | input | 1 | Store `wr_pix` as row `wr_row` |
| wr_row | input | 5 | Row index written |
| wr_pix | input | 256 | Full row of pixels, pixel c at bits c*8 |
| rd_req | input | 1 | Read request |
| rd_col | input | 1 | 1 = column read, 0 = row read |
| rd_line | input | 5 | Column index (column read) or row index (row read) |
| rd_off | input | 5 | First pixel of the 16-pixel slice along the line |
| rd_valid | output | 1 | `rd_pix` holds the result of last cycle's request |
| rd_err | output | 1 | Last request's offset was above 16 and was clamped |
| rd_pix | output | 128 | 16 pixels, first one at bits 7:0 |

## Verification
A write and a read can fall in the same cycle. The case that matters is when both hit the same row, or when a column read passes through the row being written. The bench drives a row write and a read of that row on the same clock edge. It expects the pre-write pixels, and it expects the new pixels on the read that follows. A column read that crosses a freshly rewritten row is judged the same way against the bench's own copy of the image. The bench also writes a row during idle read cycles and checks that the read output keeps its value.

// File: rtl/skw_pkg.sv
package skw_pkg;
    // default geometry of the window
    localparam int PIX_W_DEF = 8;
    localparam int WIN_DEF   = 32;
endpackage

// File: rtl/skw_rot.sv
// Barrel rotation of N pixels; N must be a power of two so index wrap is free.
module skw_rot #(
    parameter int N    = 16,
    parameter int W    = 8,
    parameter bit LEFT = 1'b0,
    localparam int SW  = $clog2(N)
) (
    input  logic [N*W-1:0] din,
    input  logic [SW-1:0]  amt,
    output logic [N*W-1:0] dout
);
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic [SW-1:0] src;
            // left: out[i] = in[i+amt]; right: out[i] = in[i-amt]
            src = LEFT ? (SW'(i) + amt) : (SW'(i) - amt);
            dout[i*W +: W] = din[src*W +: W];
        end
    end
endmodule

// File: rtl/skw_part.sv
// One quadrant: N banks, each one pixel wide and N words deep, each bank with its own read address.
module skw_part #(
    parameter int N   = 16,
    parameter int W   = 8,
    localparam int LW = $clog2(N)
) (
    input  logic           clk,
    input  logic           we,
    input  logic [LW-1:0]  waddr,
    input  logic [N*W-1:0] wdata,
    input  logic [N*LW-1:0] raddr,
    output logic [N*W-1:0] rdata
);
    for (genvar b = 0; b < N; b++) begin : g_bank
        logic [W-1:0] bank_q [N];
        always_ff @(posedge clk) begin
            if (we) bank_q[waddr] <= wdata[b*W +: W];
        end
        assign rdata[b*W +: W] = bank_q[raddr[b*LW +: LW]];
    end
endmodule

// File: rtl/skw_win_mem.sv
module skw_win_mem #(
    parameter int PIX_W = skw_pkg::PIX_W_DEF,
    parameter int WIN   = skw_pkg::WIN_DEF,
    localparam int PART    = WIN / 2,
    localparam int MB      = PART,
    localparam int LW      = $clog2(PART),
    localparam int AW      = $clog2(WIN),
    localparam int MAX_OFF = WIN - MB
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_row,
    input  logic [WIN*PIX_W-1:0] wr_pix,
    input  logic                 rd_req,
    input  logic                 rd_col,
    input  logic [AW-1:0]        rd_line,
    input  logic [AW-1:0]        rd_off,
    output logic                 rd_valid,
    output logic                 rd_err,
    output logic [MB*PIX_W-1:0]  rd_pix
);
    typedef struct packed {
        logic                valid;
        logic                err;
        logic [MB*PIX_W-1:0] pix;
    } rd_state_t;

    rd_state_t st_d, st_q;

    // ---- write side: rotate each half-row right by its local row index
    logic [PART*PIX_W-1:0] wr_rot [2];
    for (genvar h = 0; h < 2; h++) begin : g_wrot
        skw_rot #(.N(PART), .W(PIX_W), .LEFT(1'b0)) rot_i (
            .din  (wr_pix[h*PART*PIX_W +: PART*PIX_W]),
            .amt  (wr_row[LW-1:0]),
            .dout (wr_rot[h])
        );
    end

    // ---- per-bank read address: row read = local row, column read = bank - column
    logic [PART*LW-1:0] rd_addr;
    always_comb begin
        for (int b = 0; b < PART; b++) begin
            rd_addr[b*LW +: LW] = rd_col ? (LW'(b) - rd_line[LW-1:0]) : rd_line[LW-1:0];
        end
    end

    // ---- four quadrants: index = {row half, column half}
    logic [PART*PIX_W-1:0] part_rd [4];
    for (genvar p = 0; p < 4; p++) begin : g_part
        localparam bit ROW_HALF = (p / 2) == 1;
        localparam bit COL_HALF = (p % 2) == 1;
        skw_part #(.N(PART), .W(PIX_W)) part_i (
            .clk   (clk),
            .we    (wr_en && (wr_row[AW-1] == ROW_HALF)),
            .waddr (wr_row[LW-1:0]),
            .wdata (wr_rot[COL_HALF]),
            .raddr (rd_addr),
            .rdata (part_rd[p])
        );
    end

    // ---- stage 1: partition select (first and second half of the line)
    logic       line_hi;
    logic [1:0] sel_a, sel_b;
    assign line_hi = rd_line[AW-1];
    assign sel_a   = rd_col ? {1'b0, line_hi} : {line_hi, 1'b0};
    assign sel_b   = rd_col ? {1'b1, line_hi} : {line_hi, 1'b1};

    // ---- stage 2: rotate back into image order
    logic [PART*PIX_W-1:0] half_a, half_b;
    skw_rot #(.N(PART), .W(PIX_W), .LEFT(1'b1)) unrot_a_i (
        .din (part_rd[sel_a]), .amt (rd_line[LW-1:0]), .dout (half_a)
    );
    skw_rot #(.N(PART), .W(PIX_W), .LEFT(1'b1)) unrot_b_i (
        .din (part_rd[sel_b]), .amt (rd_line[LW-1:0]), .dout (half_b)
    );

    logic [WIN*PIX_W-1:0] full_line;
    assign full_line = {half_b, half_a};

    // ---- stage 3: offset slice with saturation
    logic          off_big;
    logic [AW-1:0] off_eff;
    assign off_big = rd_off > AW'(MAX_OFF);
    assign off_eff = off_big ? AW'(MAX_OFF) : rd_off;

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_req;
        st_d.err   = rd_req && off_big;
        if (rd_req) st_d.pix = full_line[off_eff*PIX_W +: MB*PIX_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_err   = st_q.err;
    assign rd_pix   = st_q.pix;
endmodule

// File: rtl/skw_win_mem_chk.sv
module skw_win_mem_chk #(
    parameter int AW      = 5,
    parameter int PIXB    = 128,
    parameter int MAX_OFF = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rd_req,
    input logic [AW-1:0]   rd_off,
    input logic            rd_valid,
    input logic            rd_err,
    input logic [PIXB-1:0] rd_pix
);
    p_valid_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    p_sat_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_off > AW'(MAX_OFF)) |=> rd_err);
    p_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_off <= AW'(MAX_OFF)) |=> !rd_err);
    p_err_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && $past(rst_n)) |=> $stable(rd_pix));
endmodule

bind skw_win_mem skw_win_mem_chk #(.AW(AW), .PIXB(MB*PIX_W), .MAX_OFF(MAX_OFF)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_off(rd_off),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_pix(rd_pix)
);

// File: tb/skw_win_mem_tb_top.sv
module skw_win_mem_tb_top;
    localparam int PW = 8, WIN = 32, MB = 16, MAXO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_req = 1'b0, rd_col = 1'b0;
    logic [4:0] wr_row = '0, rd_line = '0, rd_off = '0;
    logic [WIN*PW-1:0] wr_pix = '0;
    logic rd_valid, rd_err;
    logic [MB*PW-1:0] rd_pix;

    int checks = 0, errors = 0;
    logic [7:0] img [WIN][WIN];

    always #4 clk = ~clk;

    skw_win_mem dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_pix(wr_pix),
        .rd_req(rd_req), .rd_col(rd_col), .rd_line(rd_line), .rd_off(rd_off),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_pix(rd_pix)
    );

    task automatic chk(string tag, logic [MB*PW-1:0] act, logic [MB*PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [MB*PW-1:0] expect_slice(logic col, int line, int off);
        int o;
        logic [MB*PW-1:0] v;
        o = (off > MAXO) ? MAXO : off;
        for (int k = 0; k < MB; k++)
            v[k*PW +: PW] = col ? img[o+k][line] : img[line][o+k];
        return v;
    endfunction

    function automatic logic [WIN*PW-1:0] rand_row();
        logic [WIN*PW-1:0] v;
        for (int c = 0; c < WIN; c++) v[c*PW +: PW] = 8'($urandom);
        return v;
    endfunction

    task automatic write_row(int r, logic [WIN*PW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 5'(r); wr_pix = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c < WIN; c++) img[r][c] = d[c*PW +: PW];
    endtask

    task automatic read_chk(string tag, logic col, int line, int off);
        @(negedge clk);
        rd_req = 1'b1; rd_col = col; rd_line = 5'(line); rd_off = 5'(off);
        @(negedge clk);
        rd_req = 1'b0;
        chk({tag, " data"}, rd_pix, expect_slice(col, line, off));
        chk("R4 valid", {127'b0, rd_valid}, 128'd1);
        chk("R5 err", {127'b0, rd_err}, {127'b0, off > MAXO});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {127'b0, rd_valid}, '0);
        chk("R1 err in reset", {127'b0, rd_err}, '0);
        rd_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {127'b0, rd_valid}, '0);
        chk("R1 err after reset", {127'b0, rd_err}, '0);
    endtask

    task automatic t_fill();
        for (int r = 0; r < WIN; r++) write_row(r, rand_row());
    endtask

    task automatic t_rows();
        for (int l = 0; l < WIN; l++)
            for (int o = 0; o <= MAXO; o++) read_chk("R2 row", 1'b0, l, o);
    endtask

    task automatic t_cols();
        for (int l = 0; l < WIN; l++)
            for (int o = 0; o <= MAXO; o++) read_chk("R3 col", 1'b1, l, o);
    endtask

    task automatic t_sat();
        for (int o = MAXO + 1; o < WIN; o++) begin
            read_chk("R5 row sat", 1'b0, o, o);
            read_chk("R5 col sat", 1'b1, WIN - 1 - o, o);
        end
    endtask

    task automatic t_collide();
        logic [WIN*PW-1:0] d;
        logic [MB*PW-1:0] old_v;
        d = rand_row();
        old_v = expect_slice(1'b0, 21, 3);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 5'd21; wr_pix = d;
        rd_req = 1'b1; rd_col = 1'b0; rd_line = 5'd21; rd_off = 5'd3;
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b0;
        chk("R6 same-cycle old data", rd_pix, old_v);
        for (int c = 0; c < WIN; c++) img[21][c] = d[c*PW +: PW];
        read_chk("R6 new data next read", 1'b0, 21, 3);
    endtask

    task automatic t_hold();
        logic [MB*PW-1:0] held;
        read_chk("R7 setup", 1'b1, 9, 7);
        held = rd_pix;
        @(negedge clk);
        wr_en = 1'b1; wr_row = 5'd8; wr_pix = rand_row();
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c < WIN; c++) img[8][c] = wr_pix[c*PW +: PW];
        @(negedge clk);
        chk("R7 pix held", rd_pix, held);
        chk("R7 valid low", {127'b0, rd_valid}, '0);
    endtask

    task automatic t_rewrite();
        write_row(2, rand_row());
        write_row(30, rand_row());
        for (int l = 0; l < WIN; l++) begin
            read_chk("R8 col top", 1'b1, l, 0);
            read_chk("R8 col bottom", 1'b1, l, MAXO);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_rows();
        t_cols();
        t_sat();
        t_collide();
        t_hold();
        t_rewrite();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule